// File: doc/BRIEF.md
# Request Wait Timeout Timer

This block measures how long a DMA channel has been waiting for its peripheral to raise a request, and raises a sticky timeout flag when that wait exceeds a programmed limit. Time is counted in prescaled ticks. A 3-bit select picks a power-of-two divider of the system clock, from 256 up to 32768. A 16-bit period gives the number of such ticks that make up the limit.

Counting runs only while the timeout enable is high, the channel reports that it is waiting, and no request arrives in that cycle. If any of these conditions is missing, the prescaler and the tick counter both return to zero. The next wait therefore always starts from a clean count. After the flag sets, it stays set until the owner writes 1 to clear it. The register bus decode and the interrupt combining live outside this block.

Top module: `req_wait_timer`

## Requirements
- R1: While counting, the prescaler emits one tick every 2^(8+sel) system clocks, where `psc_sel` = 0..7 selects divisors 256, 512, ..., 32768, and two ticks are never adjacent.
- R2: With `psc_sel` = 7 the divisor is 32768, so a period of 1 sets the flag on exactly the 32768th counting clock edge.
- R3: With a nonzero `period` P and select S, `tmo_flag` reads 0 after P*2^(8+S)-1 consecutive counting edges and 1 after P*2^(8+S) edges.
- R4: Counting requires `tmo_en` = 1; with `tmo_en` = 0 the flag never sets, however long `waiting` stays high.
- R5: Once set, `tmo_flag` holds at 1 whatever `waiting`, `req_arrive` or `tmo_en` do, until it is cleared.
- R6: A 1 on `flag_clr` at a clock edge clears `tmo_flag`, unless a timeout is detected at the same edge, in which case the flag stays 1.
- R7: A `period` of 0 never sets the flag.
- R8: A cycle with `req_arrive` = 1 returns the prescaler and the tick counter to zero, so the next full period is measured from the following edge.
- R9: A cycle with `waiting` = 0 returns the prescaler and the tick counter to zero in the same way.
- R10: Within one unbroken wait the flag is set at most once; after a clear, continued waiting does not set it again.
- R11: After reset `tmo_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_en | input | 1 | Timeout counting enable |
| waiting | input | 1 | Channel is waiting for a peripheral request |
| req_arrive | input | 1 | Peripheral request arrived this cycle |
| psc_sel | input | 3 | Prescaler select; tick every 2^(8+psc_sel) clocks |
| period | input | 16 | Timeout length in prescaled ticks; 0 disables |
| flag_clr | input | 1 | Write-1-to-clear pulse for the flag |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
On every cycle, the assertions check these properties: ticks are isolated, nothing ticks when counting is off, both counters clear one edge after counting stops, a zero period never produces a hit, the flag only rises after a hit, and the flag holds or clears according to the write-1 rule. The exact edge on which the flag first reads 1 for a given select and period can only be shown by the bench's scenarios. The same holds for the effect of an enable that stays low, for restart after a request or a break in waiting, and for the absence of a second set in one wait. These scenarios count edges and compare the result against the product of the period and the divisor.

// File: rtl/rwt_pkg.sv
`timescale 1ns/1ps
package rwt_pkg;

  // Number of system clocks per prescaled tick for a given select.
  function automatic int unsigned psc_divisor(input int unsigned base,
                                              input int unsigned sel);
    psc_divisor = 32'd1 << (base + sel);
  endfunction

  // Final prescaler count before the tick fires.
  function automatic int unsigned psc_last(input int unsigned base,
                                           input int unsigned sel);
    psc_last = psc_divisor(base, sel) - 32'd1;
  endfunction

  // Width needed for the prescaler at the largest select.
  function automatic int unsigned psc_width(input int unsigned base,
                                            input int unsigned sel_w);
    psc_width = base + (32'd1 << sel_w) - 32'd1;
  endfunction

endpackage

// File: rtl/rwt_prescaler.sv
`timescale 1ns/1ps
module rwt_prescaler
  import rwt_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned PSC_BASE = 8,
  localparam int unsigned PSC_W   = psc_width(PSC_BASE, SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [PSC_W-1:0] psc_cnt
);

  logic [PSC_W-1:0] last_val;
  logic             at_last;

  always_comb begin
    last_val = PSC_W'(psc_last(PSC_BASE, 32'(sel)));
    at_last  = (psc_cnt == last_val);
    tick     = run && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
    end else if (!run || at_last) begin
      psc_cnt <= '0;
    end else begin
      psc_cnt <= psc_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rwt_wait_counter.sv
`timescale 1ns/1ps
module rwt_wait_counter #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output logic                hit,
  output logic [PERIOD_W-1:0] wait_cnt
);

  logic                saturated;
  logic [PERIOD_W-1:0] goal;

  always_comb begin
    saturated = &wait_cnt;
    goal      = period - 1'b1;
    hit       = tick && (period != '0) && (wait_cnt == goal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!run) begin
      wait_cnt <= '0;
    end else if (tick && !saturated) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rwt_sticky_flag.sv
`timescale 1ns/1ps
module rwt_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/req_wait_timer.sv
`timescale 1ns/1ps
module req_wait_timer
  import rwt_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned PSC_BASE = 8,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tmo_en,
  input  logic                waiting,
  input  logic                req_arrive,
  input  logic [SEL_W-1:0]    psc_sel,
  input  logic [PERIOD_W-1:0] period,
  input  logic                flag_clr,
  output logic                tmo_flag
);

  localparam int unsigned PSC_W = psc_width(PSC_BASE, SEL_W);

  logic                run;
  logic                tick;
  logic                hit;
  logic [PSC_W-1:0]    psc_cnt;
  logic [PERIOD_W-1:0] wait_cnt;

  assign run = tmo_en && waiting && !req_arrive;

  rwt_prescaler #(
    .SEL_W    (SEL_W),
    .PSC_BASE (PSC_BASE)
  ) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sel     (psc_sel),
    .tick    (tick),
    .psc_cnt (psc_cnt)
  );

  rwt_wait_counter #(
    .PERIOD_W (PERIOD_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .period   (period),
    .hit      (hit),
    .wait_cnt (wait_cnt)
  );

  rwt_sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (flag_clr),
    .flag  (tmo_flag)
  );

endmodule

// File: rtl/rwt_checker.sv
`timescale 1ns/1ps
module rwt_checker
  import rwt_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned PSC_BASE = 8,
  parameter int unsigned PERIOD_W = 16,
  localparam int unsigned PSC_W   = psc_width(PSC_BASE, SEL_W)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tmo_en,
  input logic                waiting,
  input logic                req_arrive,
  input logic [PERIOD_W-1:0] period,
  input logic                flag_clr,
  input logic                tmo_flag,
  input logic                run,
  input logic                tick,
  input logic                hit,
  input logic [PSC_W-1:0]    psc_cnt,
  input logic [PERIOD_W-1:0] wait_cnt
);

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

  AST_NO_TICK_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |-> !tick); // R4

  AST_FLAG_RISES_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(hit)); // R3

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag); // R5

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !tmo_flag); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && hit) |=> tmo_flag); // R6

  AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !hit); // R7

  AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_arrive |=> (psc_cnt == '0) && (wait_cnt == '0)); // R8

  AST_IDLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting |=> (psc_cnt == '0) && (wait_cnt == '0)); // R9

  AST_NO_COUNT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R9

endmodule

bind req_wait_timer rwt_checker #(
  .SEL_W    (SEL_W),
  .PSC_BASE (PSC_BASE),
  .PERIOD_W (PERIOD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmo_en     (tmo_en),
  .waiting    (waiting),
  .req_arrive (req_arrive),
  .period     (period),
  .flag_clr   (flag_clr),
  .tmo_flag   (tmo_flag),
  .run        (run),
  .tick       (tick),
  .hit        (hit),
  .psc_cnt    (psc_cnt),
  .wait_cnt   (wait_cnt)
);

// File: tb/req_wait_timer_bench.sv
`timescale 1ns/1ps
module req_wait_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmo_en = 1'b0;
  logic        waiting = 1'b0;
  logic        req_arrive = 1'b0;
  logic [2:0]  psc_sel = 3'd0;
  logic [15:0] period = 16'd0;
  logic        flag_clr = 1'b0;
  logic        tmo_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  req_wait_timer u_req_wait_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo_en     (tmo_en),
    .waiting    (waiting),
    .req_arrive (req_arrive),
    .psc_sel    (psc_sel),
    .period     (period),
    .flag_clr   (flag_clr),
    .tmo_flag   (tmo_flag)
  );

  // Clock edges of continuous waiting before the flag must read 1.
  function automatic int edges_needed(input int sel, input int per);
    int div = 256;
    for (int i = 0; i < sel; i++) div = div * 2;
    return per * div;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: tmo_flag=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic start(input int sel, input int per);
    psc_sel = 3'(sel);
    period  = 16'(per);
    tmo_en  = 1'b1;
    waiting = 1'b1;
  endtask

  task automatic pulse_clear();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  task automatic idle();
    waiting = 1'b0;
    step(2);
    pulse_clear();
  endtask

  task automatic t_reset();
    chk(tmo_flag, 1'b0, "R11 reset value");
  endtask

  task automatic t_basic();
    int n = edges_needed(0, 3);
    start(0, 3);
    step(n - 1);
    chk(tmo_flag, 1'b0, "R3 one edge before timeout");
    step(1);
    chk(tmo_flag, 1'b1, "R1 R3 timeout edge sel0 per3");
    idle();
  endtask

  task automatic t_sel2();
    int n = edges_needed(2, 2);
    start(2, 2);
    step(n - 1);
    chk(tmo_flag, 1'b0, "R1 sel2 before timeout");
    step(1);
    chk(tmo_flag, 1'b1, "R1 sel2 timeout edge");
    idle();
  endtask

  task automatic t_sel7();
    int n = edges_needed(7, 1);
    start(7, 1);
    step(n - 1);
    chk(tmo_flag, 1'b0, "R2 sel7 before timeout");
    step(1);
    chk(tmo_flag, 1'b1, "R2 sel7 timeout edge");
    idle();
  endtask

  task automatic t_clear_no_reset();
    start(0, 2);
    step(edges_needed(0, 2));
    chk(tmo_flag, 1'b1, "R10 first set");
    pulse_clear();
    chk(tmo_flag, 1'b0, "R6 write-1 clears flag");
    step(3000);
    chk(tmo_flag, 1'b0, "R10 no second set in same wait");
    idle();
  endtask

  task automatic t_sticky();
    start(0, 1);
    step(edges_needed(0, 1));
    waiting = 1'b0;
    tmo_en  = 1'b0;
    step(50);
    chk(tmo_flag, 1'b1, "R5 flag holds after wait ends");
    req_arrive = 1'b1;
    step(5);
    req_arrive = 1'b0;
    chk(tmo_flag, 1'b1, "R5 flag holds over requests");
    tmo_en = 1'b1;
    idle();
  endtask

  task automatic t_set_wins();
    int n = edges_needed(0, 2);
    start(0, 2);
    step(n - 1);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk(tmo_flag, 1'b1, "R6 set wins over same-edge clear");
    idle();
  endtask

  task automatic t_zero();
    start(0, 0);
    step(5000);
    chk(tmo_flag, 1'b0, "R7 period zero never sets");
    idle();
  endtask

  task automatic t_enable();
    int n = edges_needed(0, 3);
    psc_sel = 3'd0;
    period  = 16'd3;
    tmo_en  = 1'b0;
    waiting = 1'b1;
    step(3000);
    chk(tmo_flag, 1'b0, "R4 disabled never sets");
    tmo_en = 1'b1;
    step(n - 1);
    chk(tmo_flag, 1'b0, "R4 count starts at enable");
    step(1);
    chk(tmo_flag, 1'b1, "R4 enabled timeout edge");
    idle();
  endtask

  task automatic t_request();
    int n = edges_needed(0, 3);
    start(0, 3);
    step(700);
    req_arrive = 1'b1;
    step(1);
    req_arrive = 1'b0;
    step(n - 1);
    chk(tmo_flag, 1'b0, "R8 restarted by request");
    step(1);
    chk(tmo_flag, 1'b1, "R8 full period after request");
    idle();
  endtask

  task automatic t_leave();
    int n = edges_needed(1, 2);
    start(1, 2);
    step(n - 10);
    waiting = 1'b0;
    step(1);
    waiting = 1'b1;
    step(n - 1);
    chk(tmo_flag, 1'b0, "R9 restarted by leaving wait");
    step(1);
    chk(tmo_flag, 1'b1, "R9 full period after rewait");
    idle();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_basic();
    t_sel2();
    t_clear_no_reset();
    t_sticky();
    t_set_wins();
    t_zero();
    t_enable();
    t_request();
    t_leave();
    t_sel7();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule